// File: doc/BRIEF.md
# Four-Channel PWM Controller Register Block

This block is the register front end of a four-channel pulse-width modulator. A simple 32-bit register bus carries a 12-bit byte address, a write strobe, a read strobe, write data and combinational read data. Through it, software starts and stops channels, watches which channels are live, collects period-start events and programs each channel's mode, duty and period. The waveform counters are separate instances. They receive the run bits and the configuration from this block, and they return one pulse per channel whenever a new period begins.

Channels are started and stopped through two command registers. A 1 bit acts on its channel and a 0 bit does nothing, so no read-modify-write is ever needed. A stop is only a request. The channel keeps running, and keeps showing as live in the status register, until its next period boundary, so software can poll for the moment the output goes quiet. Duty and period can each be written directly or staged in an update register. A staged value lands at the next period boundary of a running channel, so the waveform never shows a half-changed period.

Top module: `pwm_ctrl_regs`

## Requirements
- R1: After reset, all run bits, event bits and channel registers are zero, and every read returns zero.
- R2: A write to offset 0x04 starts every channel n whose bit n is 1, from the next cycle on. Bits that are 0 change nothing, and a read of 0x04 or 0x08 returns zero. Status at 0x0C shows the run bits of channels 0 to 3 in bits [3:0].
- R3: A write to offset 0x08 with bit n set requests a stop of running channel n. Status bit n stays 1 until a period pulse of channel n is sampled, and clears on that clock edge. A stop written to an idle channel has no effect.
- R4: A start written while a stop is pending cancels the stop, and the channel keeps running through later period pulses.
- R5: Event bit n at offset 0x1C sets on a period pulse of channel n while that channel runs, and stays set until it is read. Pulses of stopped channels set nothing.
- R6: A read of 0x1C returns the event bits and clears all of them. A period pulse sampled in the same cycle as that read is kept.
- R7: Channel n's window starts at 0x200 + n*0x20. Its mode register at window offset 0x00 holds the prescaler in [3:0], the inverted polarity in bit 9 and the update-target select in bit 10. All other mode bits read as zero.
- R8: Duty at window offset 0x04 and period at 0x0C are written directly, read back and drive the channel outputs from the next cycle on. A channel's registers change only through writes to its own window.
- R9: Duty-update at window offset 0x08 and period-update at 0x10 hold a staged value that reads back. The staged value is copied into the live duty or period at the next period pulse of the running channel. Nothing is copied while the channel is stopped.
- R10: Reads of unmapped offsets return zero and writes to them change nothing. Unmapped offsets include unused window offsets and windows beyond the last channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; needed for read-to-clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| period_end_i | input | NCH | Per-channel pulse: new period begins |
| ch_en_o | output | NCH | Run bit per channel |
| ch_prescale_o | output | NCH x 4 | Prescaler field per channel |
| ch_invert_o | output | NCH | Polarity inversion per channel |
| ch_upd_sel_o | output | NCH | Update-target select per channel |
| ch_duty_o | output | NCH x DW | Live duty per channel |
| ch_period_o | output | NCH x DW | Live period per channel |

## Verification
A wrong stop-pending flag shows up at the status register at the first period pulse. The channel either drops a cycle early, or never drops and stays live. A lost or sticky event bit shows up on the next read of 0x1C, which the bench makes right after each pulse pattern, including the case where a pulse and the read land in the same cycle. A bad window decode or a bad staged transfer shows up on the channel outputs one cycle after the write or the pulse, and the bench compares those outputs against the read-back values of every channel.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  localparam int ADDR_W = 12;
  localparam logic [11:0] OFF_START  = 12'h004;
  localparam logic [11:0] OFF_STOP   = 12'h008;
  localparam logic [11:0] OFF_LIVE   = 12'h00C;
  localparam logic [11:0] OFF_EVENT  = 12'h01C;
  localparam logic [2:0]  WIN_TAG    = 3'b001;  // 0x200..0x3FF
  localparam logic [4:0]  CH_MODE     = 5'h00;
  localparam logic [4:0]  CH_DUTY     = 5'h04;
  localparam logic [4:0]  CH_DUTY_STG = 5'h08;
  localparam logic [4:0]  CH_PER      = 5'h0C;
  localparam logic [4:0]  CH_PER_STG  = 5'h10;

  typedef struct packed {
    logic       upd_sel;
    logic       invert;
    logic [3:0] prescale;
  } ch_mode_t;
endpackage

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] start_i,
  input  logic [NCH-1:0] stop_i,
  input  logic [NCH-1:0] period_end_i,
  input  logic           evt_rd_i,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] evt_o
);
  logic [NCH-1:0] run_q, stop_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      stop_q <= '0;
      evt_q  <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (start_i[i]) begin
          run_q[i]  <= 1'b1;
          stop_q[i] <= 1'b0;
        end else if (stop_q[i] && period_end_i[i]) begin
          run_q[i]  <= 1'b0;
          stop_q[i] <= 1'b0;
        end else if (stop_i[i] && run_q[i]) begin
          stop_q[i] <= 1'b1;
        end
      end
      // new events survive a same-cycle read
      evt_q <= (evt_rd_i ? '0 : evt_q) | (period_end_i & run_q);
    end
  end

  assign run_o = run_q;
  assign evt_o = evt_q;

  p_rise_needs_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q & ~$past(run_q) & ~$past(start_i)) == '0);
  p_fall_on_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~run_q & $past(run_q) & ~$past(period_end_i)) == '0);
  p_evt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_rd_i |=> ($past(evt_q) & ~evt_q) == '0);
  p_evt_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rd_i |=> (evt_q & ~$past(period_end_i & run_q)) == '0);
endmodule

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
  import pwm_ctrl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [4:0]    off_i,
  input  logic [31:0]   wdata_i,
  input  logic          tick_i,
  output logic [31:0]   rdata_o,
  output ch_mode_t      mode_o,
  output logic [DW-1:0] duty_o,
  output logic [DW-1:0] period_o
);
  ch_mode_t      mode_q;
  logic [DW-1:0] duty_q, per_q, duty_stg_q, per_stg_q;
  logic          duty_pend_q, per_pend_q;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      duty_q      <= '0;
      per_q       <= '0;
      duty_stg_q  <= '0;
      per_stg_q   <= '0;
      duty_pend_q <= 1'b0;
      per_pend_q  <= 1'b0;
    end else begin
      if (tick_i && duty_pend_q) begin
        duty_q      <= duty_stg_q;
        duty_pend_q <= 1'b0;
      end
      if (tick_i && per_pend_q) begin
        per_q      <= per_stg_q;
        per_pend_q <= 1'b0;
      end
      if (wr_i) begin
        unique case (off_i)
          CH_MODE:     mode_q <= '{upd_sel: wdata_i[10], invert: wdata_i[9], prescale: wdata_i[3:0]};
          CH_DUTY:     duty_q <= wdata_i[DW-1:0];
          CH_DUTY_STG: begin duty_stg_q <= wdata_i[DW-1:0]; duty_pend_q <= 1'b1; end
          CH_PER:      per_q <= wdata_i[DW-1:0];
          CH_PER_STG:  begin per_stg_q <= wdata_i[DW-1:0]; per_pend_q <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (off_i)
      CH_MODE:     rdata_o = {21'd0, mode_q.upd_sel, mode_q.invert, 5'd0, mode_q.prescale};
      CH_DUTY:     rdata_o = 32'(duty_q);
      CH_DUTY_STG: rdata_o = 32'(duty_stg_q);
      CH_PER:      rdata_o = 32'(per_q);
      CH_PER_STG:  rdata_o = 32'(per_stg_q);
      default:     rdata_o = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign duty_o   = duty_q;
  assign period_o = per_q;

  p_stage_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && duty_pend_q && !(wr_i && off_i == CH_DUTY)) |=> duty_q == $past(duty_stg_q));
  p_cfg_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> ($stable(duty_q) && $stable(per_q) && $stable(mode_q)));
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_ctrl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NCH-1:0]            period_end_i,
  output logic [NCH-1:0]            ch_en_o,
  output logic [NCH-1:0][3:0]       ch_prescale_o,
  output logic [NCH-1:0]            ch_invert_o,
  output logic [NCH-1:0]            ch_upd_sel_o,
  output logic [NCH-1:0][DW-1:0]    ch_duty_o,
  output logic [NCH-1:0][DW-1:0]    ch_period_o
);
  localparam int IDX_W = 4;  // window index field addr[8:5]

  logic [IDX_W-1:0] win_idx;
  logic [4:0]       win_off;
  logic             win_hit, evt_rd;
  logic [NCH-1:0]   start_set, stop_set, run, evt;
  logic [31:0]      ch_rd [NCH];

  assign win_idx = addr_i[8:5];
  assign win_off = addr_i[4:0];
  assign win_hit = (addr_i[11:9] == WIN_TAG) && ({1'b0, win_idx} < 5'(NCH));
  assign start_set = (we_i && addr_i == OFF_START) ? wdata_i[NCH-1:0] : '0;
  assign stop_set  = (we_i && addr_i == OFF_STOP)  ? wdata_i[NCH-1:0] : '0;
  assign evt_rd    = re_i && (addr_i == OFF_EVENT);

  pwm_run_ctrl #(.NCH(NCH)) u_run (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_set),
    .stop_i       (stop_set),
    .period_end_i (period_end_i),
    .evt_rd_i     (evt_rd),
    .run_o        (run),
    .evt_o        (evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ch_mode_t mode;
    pwm_ch_regs #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (we_i && win_hit && win_idx == IDX_W'(g)),
      .off_i    (win_off),
      .wdata_i  (wdata_i),
      .tick_i   (period_end_i[g] && run[g]),
      .rdata_o  (ch_rd[g]),
      .mode_o   (mode),
      .duty_o   (ch_duty_o[g]),
      .period_o (ch_period_o[g])
    );
    assign ch_prescale_o[g] = mode.prescale;
    assign ch_invert_o[g]   = mode.invert;
    assign ch_upd_sel_o[g]  = mode.upd_sel;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_LIVE)       rdata_o = 32'(run);
    else if (addr_i == OFF_EVENT) rdata_o = 32'(evt);
    else begin
      for (int i = 0; i < NCH; i++)
        if (win_hit && win_idx == IDX_W'(i)) rdata_o = ch_rd[i];
    end
  end

  assign ch_en_o = run;

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_hit && addr_i != OFF_LIVE && addr_i != OFF_EVENT) |-> rdata_o == '0);
  p_live_is_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_LIVE) |-> rdata_o[NCH-1:0] == ch_en_o);
endmodule

// File: tb/pwm_ctrl_regs_bench.sv
module pwm_ctrl_regs_bench;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic we_i = 1'b0, re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NCH-1:0] period_end_i = '0;
  logic [NCH-1:0] ch_en_o, ch_invert_o, ch_upd_sel_o;
  logic [NCH-1:0][3:0] ch_prescale_o;
  logic [NCH-1:0][DW-1:0] ch_duty_o, ch_period_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_ctrl_regs #(.NCH(NCH), .DW(DW)) u_pwm_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .period_end_i(period_end_i),
    .ch_en_o(ch_en_o), .ch_prescale_o(ch_prescale_o), .ch_invert_o(ch_invert_o),
    .ch_upd_sel_o(ch_upd_sel_o), .ch_duty_o(ch_duty_o), .ch_period_o(ch_period_o)
  );

  function automatic logic [11:0] win(input int ch, input logic [4:0] off);
    return 12'h200 + 12'(ch * 32) + 12'(off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr_i = a; re_i = 1'b1;
    #5 d = rdata_o;
    @(negedge clk); re_i = 1'b0; addr_i = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); period_end_i = m;
    @(negedge clk); period_end_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 run outputs", 32'(ch_en_o), 0);
    rd(12'h00C, d); check("R1 status", d, 0);
    rd(12'h01C, d); check("R1 events", d, 0);
    rd(win(2, 5'h0C), d); check("R1 ch2 period", d, 0);
    check("R1 duty outputs", 32'(ch_duty_o), 0);
  endtask

  task automatic t_start;
    logic [31:0] d;
    wr(12'h004, 32'h5);
    rd(12'h00C, d); check("R2 start 0101", d, 32'h5);
    wr(12'h004, 32'h0);
    rd(12'h00C, d); check("R2 zero bits no effect", d, 32'h5);
    check("R2 run outputs", 32'(ch_en_o), 32'h5);
    rd(12'h004, d); check("R2 start reg reads zero", d, 0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(12'h008, 32'h1);
    rd(12'h00C, d); check("R3 stop pending stays live", d, 32'h5);
    pulse(4'b0100);
    rd(12'h00C, d); check("R3 other channel pulse", d, 32'h5);
    pulse(4'b0001);
    rd(12'h00C, d); check("R3 stopped at boundary", d, 32'h4);
    wr(12'h008, 32'h2);
    pulse(4'b0010);
    wr(12'h004, 32'h0);
    rd(12'h00C, d); check("R3 stop of idle channel", d, 32'h4);
  endtask

  task automatic t_cancel;
    logic [31:0] d;
    wr(12'h008, 32'h4);
    wr(12'h004, 32'h4);
    pulse(4'b0100);
    rd(12'h00C, d); check("R4 start cancels stop", d, 32'h4);
    wr(12'h008, 32'h4);
    pulse(4'b0100);
    rd(12'h00C, d); check("R4 later stop works", d, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    rd(12'h01C, d);  // drain
    wr(12'h004, 32'h3);
    pulse(4'b1111);
    rd(12'h01C, d); check("R5 only running channels", d, 32'h3);
    rd(12'h01C, d); check("R6 cleared by read", d, 32'h0);
    pulse(4'b0010);
    @(negedge clk); addr_i = 12'h01C; re_i = 1'b1; period_end_i = 4'b0001;
    #5 d = rdata_o;
    @(negedge clk); re_i = 1'b0; addr_i = '0; period_end_i = '0;
    check("R6 read returns prior bits", d, 32'h2);
    rd(12'h01C, d); check("R6 same-cycle event kept", d, 32'h1);
    wr(12'h008, 32'h3);
    pulse(4'b0011);
    rd(12'h01C, d);
  endtask

  task automatic t_window;
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      wr(win(c, 5'h04), 32'h100 + 32'(c));
      wr(win(c, 5'h0C), 32'h900 + 32'(c));
    end
    for (int c = 0; c < NCH; c++) begin
      rd(win(c, 5'h04), d); check("R8 duty readback", d, 32'h100 + 32'(c));
      rd(win(c, 5'h0C), d); check("R8 period readback", d, 32'h900 + 32'(c));
      check("R8 duty output", 32'(ch_duty_o[c]), 32'h100 + 32'(c));
      check("R8 period output", 32'(ch_period_o[c]), 32'h900 + 32'(c));
    end
    wr(win(2, 5'h00), 32'hFFFF_FFFF);
    rd(win(2, 5'h00), d); check("R7 mode fields", d, 32'h0000_060F);
    check("R7 prescale out", 32'(ch_prescale_o[2]), 32'hF);
    check("R7 invert/upd out", {30'd0, ch_invert_o[2], ch_upd_sel_o[2]}, 32'h3);
    rd(win(1, 5'h00), d); check("R7 neighbour mode untouched", d, 0);
    wr(win(3, 5'h00), 32'h0000_0205);
    rd(win(3, 5'h00), d); check("R7 polarity only", d, 32'h205);
  endtask

  task automatic t_update;
    logic [31:0] d;
    wr(12'h004, 32'h2);
    wr(win(1, 5'h04), 32'h10);
    wr(win(1, 5'h08), 32'h20);
    wr(win(1, 5'h10), 32'h40);
    rd(win(1, 5'h08), d); check("R9 staged duty readback", d, 32'h20);
    rd(win(1, 5'h04), d); check("R9 live duty before boundary", d, 32'h10);
    check("R9 duty output before boundary", 32'(ch_duty_o[1]), 32'h10);
    pulse(4'b0010);
    check("R9 duty lands", 32'(ch_duty_o[1]), 32'h20);
    check("R9 period lands", 32'(ch_period_o[1]), 32'h40);
    wr(win(3, 5'h08), 32'h77);
    pulse(4'b1000);
    check("R9 stopped channel no transfer", 32'(ch_duty_o[3]), 32'h103);
    wr(12'h008, 32'h2);
    pulse(4'b0010);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h000, d); check("R10 offset 0", d, 0);
    rd(12'h010, d); check("R10 global gap", d, 0);
    rd(win(0, 5'h14), d); check("R10 window gap", d, 0);
    rd(12'h280, d); check("R10 window past last channel", d, 0);
    wr(12'h284, 32'hDEAD);
    wr(win(0, 5'h14), 32'hBEEF);
    wr(12'h0C0, 32'hF);
    for (int c = 0; c < NCH; c++)
      check("R10 duty untouched", 32'(ch_duty_o[c]), (c == 1) ? 32'h20 : (c == 3) ? 32'h103 : 32'h100 + 32'(c));
    rd(win(0, 5'h04), d); check("R10 ch0 duty", d, 32'h100);
    check("R10 no channel started", 32'(ch_en_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_start();
    t_stop();
    t_cancel();
    t_events();
    t_window();
    t_update();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule